// File: doc/BRIEF.md
# Pooled Threshold Binarizer

This stage sits behind an array of binary dot-product engines and turns their signed integer counts into the next layer's activations. Counts for one channel's feature map arrive one per valid beat in raster order (left to right, then top to bottom), with the channel number carried on every beat. When pooling is on, the block keeps the largest count of each non-overlapping 2×2 window as the window completes. It does not wait for the whole map. When pooling is off, every count goes straight through.

Each surviving value is then compared with a signed per-channel threshold held in a small table. Normalization, bias compensation and the sign step are all folded into that one greater-or-equal test. A final-layer mode replaces the bit with the signed difference between the value and the channel's threshold, which gives the classifier a normalized integer score. Pooling is applied to integer counts before the comparison. This is only equivalent to pooling after binarization when the folded scale is positive, and the block assumes that it is.

The map width and height must be even, with a width of at least 4. Both mode inputs are held steady from the first beat of a map until its last result has left the block.

Top module: `pool_binarize`

## Requirements
- R1: After reset, and on every cycle without a result, `out_valid`, `out_bit` and `out_value` are all 0.
- R2: With `cfg_pool` low, each accepted beat produces exactly one result two clock cycles later, and that result carries the beat's channel.
- R3: With `cfg_pool` high, a result appears two cycles after the beat at an odd column and odd row (both 0-based). Its value is the signed maximum of that beat, its left neighbour, and the two counts directly above them. No other beat produces a result.
- R4: In binary mode (`cfg_final` low), `out_bit` is 1 exactly when the value is greater than or equal to the channel's threshold, with both taken as signed, and `out_value` is 0.
- R5: In final mode (`cfg_final` high), `out_value` is the signed value minus the channel's threshold, `CNT_W+1` bits wide, and `out_bit` is 0.
- R6: A threshold write is used by every result whose triggering beat is presented in the same cycle as the write or later. A result whose beat came one cycle before the write still uses the old threshold.
- R7: Idle cycles between beats do not move the raster position. After `MAP_W*MAP_H` beats the position returns to column 0, row 0, so maps can follow one another with no gap.
- R8: In pooled mode, two results never appear in consecutive cycles, and each map yields `(MAP_W/2)*(MAP_H/2)` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pool | input | 1 | 1 = 2×2 max-pool, 0 = pass every count |
| cfg_final | input | 1 | 1 = output signed difference, 0 = output threshold bit |
| in_valid | input | 1 | A count is presented this cycle |
| in_count | input | CNT_W | Signed count |
| in_ch | input | CH_W | Channel of the count |
| thr_we | input | 1 | Write a threshold this cycle |
| thr_ch | input | CH_W | Channel whose threshold is written |
| thr_value | input | CNT_W | Signed threshold value |
| out_valid | output | 1 | A result is presented |
| out_bit | output | 1 | Binary activation |
| out_value | output | CNT_W+1 | Signed normalized score in final mode |
| out_ch | output | CH_W | Channel of the result |

## Verification
A threshold write and a window closing can land in the same cycle, and the closing result then reads the table in the cycle the write takes effect. The bench provokes this by streaming a pooled map while writing a fresh threshold for that same channel on every beat. Each expected result is computed from a model table that takes each write at the moment it is driven. A window result therefore uses the write presented with its own beat, and never the write presented one cycle after it. Any off-by-one in the ordering between the table and the comparison shows up as a wrong bit against the expected value.

// File: rtl/pb_pkg.sv
// Shared types for the pooled threshold binarizer.
// Assumes nothing beyond the raster order of the input stream.
package pb_pkg;
    // Role of a raster position inside its 2x2 pooling window.
    typedef enum logic [1:0] {
        POS_TOP_LEFT  = 2'b00,  // even row, even column: start a pair
        POS_TOP_RIGHT = 2'b01,  // even row, odd column: store pair maximum
        POS_BOT_LEFT  = 2'b10,  // odd row, even column: start a pair
        POS_BOT_RIGHT = 2'b11   // odd row, odd column: window closes
    } pos_kind_e;
endpackage

// File: rtl/pb_pos_track.sv
// Raster position tracker.
// Counts accepted beats across a MAP_W x MAP_H map and wraps to (0,0) after
// the last one. It reports the window role of the current beat and the index
// of its column pair. Assumes MAP_W is even and >= 4, and MAP_H is even.
module pb_pos_track #(
    parameter int MAP_W = 8,
    parameter int MAP_H = 4,
    localparam int CW = $clog2(MAP_W),
    localparam int RW = (MAP_H > 2) ? $clog2(MAP_H) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [CW-2:0]     pair_idx,
    output pb_pkg::pos_kind_e kind
);
    logic [CW-1:0] col;
    logic [RW-1:0] row;

    // Step the position on each accepted beat, wrapping at row and map ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (adv) begin
            if (col == CW'(MAP_W - 1)) begin
                col <= '0;
                row <= (row == RW'(MAP_H - 1)) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Decode the window role and pair index from the low position bits.
    always_comb begin
        pair_idx = col[CW-1:1];
        kind     = pb_pkg::pos_kind_e'({row[0], col[0]});
    end
endmodule

// File: rtl/pb_pool_stage.sv
// Streaming 2x2 max-pool stage with a bypass.
// In pooled mode it keeps the first count of each pair, stores each pair
// maximum of an even row in a half-width line buffer, and emits the window
// maximum when the odd-row pair closes. In bypass it registers every count.
// One register stage. Assumes the pool mode is steady across a map.
module pb_pool_stage #(
    parameter int MAP_W = 8,
    parameter int CNT_W = 10,
    parameter int CH_W  = 2,
    localparam int LB_D = MAP_W / 2,
    localparam int PW   = $clog2(MAP_W) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pool_en,
    input  logic                    in_valid,
    input  logic signed [CNT_W-1:0] in_count,
    input  logic [CH_W-1:0]         in_ch,
    input  logic [PW-1:0]           pair_idx,
    input  pb_pkg::pos_kind_e       kind,
    output logic                    pv_valid,
    output logic signed [CNT_W-1:0] pv_value,
    output logic [CH_W-1:0]         pv_ch
);
    logic signed [CNT_W-1:0] hold_q;
    logic signed [CNT_W-1:0] lb [LB_D];
    logic [LB_D-1:0]         lb_we;
    logic signed [CNT_W-1:0] pair_max;
    logic signed [CNT_W-1:0] win_max;

    function automatic logic signed [CNT_W-1:0] smax(
        input logic signed [CNT_W-1:0] a,
        input logic signed [CNT_W-1:0] b
    );
        return (a >= b) ? a : b;
    endfunction

    // Maximum of the current pair, and of the pair with the row above.
    always_comb begin
        pair_max = smax(hold_q, in_count);
        win_max  = smax(lb[pair_idx], pair_max);
    end

    // One write enable per line-buffer slot.
    for (genvar g = 0; g < LB_D; g++) begin : g_lb_we
        assign lb_we[g] = pool_en && in_valid && (kind == pb_pkg::POS_TOP_RIGHT)
                          && (pair_idx == PW'(g));
    end

    // Store even-row pair maxima until the odd row closes each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LB_D; i++) lb[i] <= '0;
        end else begin
            for (int i = 0; i < LB_D; i++) if (lb_we[i]) lb[i] <= pair_max;
        end
    end

    // Keep the first count of each horizontal pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (pool_en && in_valid && !kind[0]) begin
            hold_q <= in_count;
        end
    end

    // Emit a pooled maximum on window close, or every count in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_valid <= 1'b0;
            pv_value <= '0;
            pv_ch    <= '0;
        end else begin
            pv_valid <= 1'b0;
            pv_value <= '0;
            pv_ch    <= '0;
            if (in_valid && !pool_en) begin
                pv_valid <= 1'b1;
                pv_value <= in_count;
                pv_ch    <= in_ch;
            end else if (in_valid && kind == pb_pkg::POS_BOT_RIGHT) begin
                pv_valid <= 1'b1;
                pv_value <= win_max;
                pv_ch    <= in_ch;
            end
        end
    end
endmodule

// File: rtl/pb_thresh_stage.sv
// Per-channel threshold table and comparator.
// Holds one signed threshold per channel, written through a simple port.
// Each incoming value gives either a greater-or-equal bit or the signed
// difference to the threshold, in one register stage. A write in the same
// cycle as a compare is not seen by that compare.
module pb_thresh_stage #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 10,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    final_en,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic signed [CNT_W-1:0] wr_value,
    input  logic                    pv_valid,
    input  logic signed [CNT_W-1:0] pv_value,
    input  logic [CH_W-1:0]         pv_ch,
    output logic                    out_valid,
    output logic                    out_bit,
    output logic signed [CNT_W:0]   out_value,
    output logic [CH_W-1:0]         out_ch
);
    logic signed [CNT_W-1:0] thr [N_CH];
    logic [N_CH-1:0]         thr_sel;
    logic signed [CNT_W-1:0] thr_rd;
    logic signed [CNT_W:0]   diff;

    // Decode the write port into per-entry enables.
    for (genvar g = 0; g < N_CH; g++) begin : g_thr_sel
        assign thr_sel[g] = wr_en && (wr_ch == CH_W'(g));
    end

    // Hold the per-channel thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) thr[i] <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) if (thr_sel[i]) thr[i] <= wr_value;
        end
    end

    // Read the channel threshold and form the widened signed difference.
    always_comb begin
        thr_rd = thr[pv_ch];
        diff   = {pv_value[CNT_W-1], pv_value} - {thr_rd[CNT_W-1], thr_rd};
    end

    // Register the bit or score; all fields read 0 when there is no result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_value <= '0;
            out_ch    <= '0;
        end else begin
            out_valid <= pv_valid;
            out_ch    <= pv_valid ? pv_ch : '0;
            out_bit   <= pv_valid && !final_en && !diff[CNT_W];
            out_value <= (pv_valid && final_en) ? diff : '0;
        end
    end
endmodule

// File: rtl/pool_binarize.sv
// Pooled threshold binarizer, top level.
// Counts in raster order go through an optional 2x2 max-pool and then a
// per-channel threshold compare. The result appears two cycles after the
// triggering beat. Assumes MAP_W even and >= 4, MAP_H even, N_CH >= 2,
// and mode inputs held steady while a map is in flight.
module pool_binarize #(
    parameter int MAP_W = 8,
    parameter int MAP_H = 4,
    parameter int N_CH  = 4,
    parameter int CNT_W = 10,
    localparam int CH_W = $clog2(N_CH),
    localparam int PW   = $clog2(MAP_W) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_pool,
    input  logic                    cfg_final,
    input  logic                    in_valid,
    input  logic signed [CNT_W-1:0] in_count,
    input  logic [CH_W-1:0]         in_ch,
    input  logic                    thr_we,
    input  logic [CH_W-1:0]         thr_ch,
    input  logic signed [CNT_W-1:0] thr_value,
    output logic                    out_valid,
    output logic                    out_bit,
    output logic signed [CNT_W:0]   out_value,
    output logic [CH_W-1:0]         out_ch
);
    logic [PW-1:0]           pair_idx;
    pb_pkg::pos_kind_e       kind;
    logic                    pv_valid;
    logic signed [CNT_W-1:0] pv_value;
    logic [CH_W-1:0]         pv_ch;

    pb_pos_track #(.MAP_W(MAP_W), .MAP_H(MAP_H)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (in_valid),
        .pair_idx (pair_idx),
        .kind     (kind)
    );

    pb_pool_stage #(.MAP_W(MAP_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pool_en  (cfg_pool),
        .in_valid (in_valid),
        .in_count (in_count),
        .in_ch    (in_ch),
        .pair_idx (pair_idx),
        .kind     (kind),
        .pv_valid (pv_valid),
        .pv_value (pv_value),
        .pv_ch    (pv_ch)
    );

    pb_thresh_stage #(.N_CH(N_CH), .CNT_W(CNT_W)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .final_en  (cfg_final),
        .wr_en     (thr_we),
        .wr_ch     (thr_ch),
        .wr_value  (thr_value),
        .pv_valid  (pv_valid),
        .pv_value  (pv_value),
        .pv_ch     (pv_ch),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_value (out_value),
        .out_ch    (out_ch)
    );
endmodule

// File: rtl/pb_chk.sv
// Port-level properties of the pooled threshold binarizer, bound to the top.
// Assumes mode inputs are steady while a map is in flight.
module pb_chk #(
    parameter int CNT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_pool,
    input logic                    cfg_final,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic                    out_bit,
    input logic signed [CNT_W:0]   out_value
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_bit && out_value == '0));

    // R2
    bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_pool) |-> ##2 out_valid);

    // R3
    out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R5
    final_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_final) |-> !out_bit);

    // R8
    pool_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pool && out_valid) |=> !out_valid);
endmodule

bind pool_binarize pb_chk #(.CNT_W(CNT_W)) u_pb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pool  (cfg_pool),
    .cfg_final (cfg_final),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_value (out_value)
);

// File: tb/tb_pool_binarize.sv
`timescale 1ns/100ps
module tb_pool_binarize;
    localparam int W   = 8;
    localparam int H   = 4;
    localparam int NC  = 4;
    localparam int CW  = 10;
    localparam int CHW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pool = 1'b0, cfg_final = 1'b0;
    logic in_valid = 1'b0;
    logic signed [CW-1:0] in_count = '0;
    logic [CHW-1:0] in_ch = '0;
    logic thr_we = 1'b0;
    logic [CHW-1:0] thr_ch = '0;
    logic signed [CW-1:0] thr_value = '0;
    logic out_valid, out_bit;
    logic signed [CW:0] out_value;
    logic [CHW-1:0] out_ch;

    pool_binarize #(.MAP_W(W), .MAP_H(H), .N_CH(NC), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pool(cfg_pool), .cfg_final(cfg_final),
        .in_valid(in_valid), .in_count(in_count), .in_ch(in_ch),
        .thr_we(thr_we), .thr_ch(thr_ch), .thr_value(thr_value),
        .out_valid(out_valid), .out_bit(out_bit), .out_value(out_value),
        .out_ch(out_ch)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  b;
        int    v;
        int    ch;
        string tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    int thr_m[NC];
    int grid[2][W];
    int bcol = 0, brow = 0;
    string cur_tag = "R2";
    bit done = 1'b0;

    // Queue the expected result of a surviving value.
    task automatic push(int val, int ch);
        exp_t e;
        e.at  = cyc + 2;
        e.ch  = ch;
        e.tag = cur_tag;
        if (cfg_final) begin e.v = val - thr_m[ch]; e.b = 1'b0; end
        else           begin e.v = 0; e.b = (val >= thr_m[ch]); end
        q.push_back(e);
    endtask

    // Arithmetic model of the raster position and pooling.
    task automatic model(int val, int ch);
        grid[brow % 2][bcol] = val;
        if (!cfg_pool) push(val, ch);
        else if ((brow % 2 == 1) && (bcol % 2 == 1)) begin
            int m = grid[0][bcol-1];
            if (grid[0][bcol] > m) m = grid[0][bcol];
            if (grid[1][bcol-1] > m) m = grid[1][bcol-1];
            if (grid[1][bcol] > m) m = grid[1][bcol];
            push(m, ch);
        end
        if (bcol == W - 1) begin bcol = 0; brow = (brow == H - 1) ? 0 : brow + 1; end
        else bcol = bcol + 1;
    endtask

    // Compare outputs at this falling edge against the expectation queue.
    task automatic observe();
        if (q.size() > 0 && q[0].at == cyc) begin
            exp_t e = q.pop_front();
            checks++;
            if (!out_valid || out_bit !== e.b || int'(out_value) != e.v || int'(out_ch) != e.ch) begin
                errors++;
                $display("FAIL %s cyc %0d: valid %0b bit %0b value %0d ch %0d, expected bit %0b value %0d ch %0d",
                         e.tag, cyc, out_valid, out_bit, out_value, out_ch, e.b, e.v, e.ch);
            end
        end else begin
            checks++;
            if (out_valid !== 1'b0 || out_bit !== 1'b0 || out_value != 0) begin
                errors++;
                $display("FAIL R1/R3/R8 cyc %0d: unexpected valid %0b bit %0b value %0d, expected all 0",
                         cyc, out_valid, out_bit, out_value);
            end
        end
    endtask

    task automatic step(bit v, int cnt, int ch, bit we = 1'b0, int wch = 0, int wval = 0);
        @(negedge clk);
        observe();
        in_valid  = v;
        in_count  = CW'(cnt);
        in_ch     = CHW'(ch);
        thr_we    = we;
        thr_ch    = CHW'(wch);
        thr_value = CW'(wval);
        if (we) thr_m[wch] = wval;
        if (v) model(cnt, ch);
    endtask

    function automatic int gen(int i, int s);
        return ((i * 29 + s * 53) % 97) - 48;
    endfunction

    // Stream one map. kind: 0 generic, 1 extremes, 2 around threshold.
    task automatic run_map(bit pool, bit fin, int ch, int seed, bit gaps, bit wr, int kind, string tag);
        cfg_pool  = pool;
        cfg_final = fin;
        cur_tag   = tag;
        for (int i = 0; i < W * H; i++) begin
            int v = gen(i, seed);
            if (kind == 1) v = (i % 5 == 0) ? 511 : ((i % 5 == 1) ? -512 : v);
            if (kind == 2) v = thr_m[ch] + (i % 3) - 1;
            if (gaps && (i % 3 == 1)) step(1'b0, 0, 0);
            if (wr) step(1'b1, v, ch, 1'b1, ch, gen(i, seed + 7) / 2);
            else    step(1'b1, v, ch);
        end
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) thr_m[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset
        cur_tag = "R1";
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0);
        // Load thresholds: 0, 5, -7, 20
        step(1'b0, 0, 0, 1'b1, 0, 0);
        step(1'b0, 0, 0, 1'b1, 1, 5);
        step(1'b0, 0, 0, 1'b1, 2, -7);
        step(1'b0, 0, 0, 1'b1, 3, 20);
        // R2 / R4: bypass binary, continuous
        run_map(1'b0, 1'b0, 1, 1, 1'b0, 1'b0, 0, "R2");
        // R3 / R7: pooled binary with idle gaps, two maps back to back
        run_map(1'b1, 1'b0, 2, 2, 1'b1, 1'b0, 0, "R3");
        run_map(1'b1, 1'b0, 0, 3, 1'b0, 1'b0, 0, "R7");
        // R4: values at threshold -1, 0, +1, pooled and bypass
        run_map(1'b1, 1'b0, 3, 4, 1'b0, 1'b0, 2, "R4");
        run_map(1'b0, 1'b0, 1, 5, 1'b0, 1'b0, 2, "R4");
        // R5: final mode, bypass and pooled, including extreme counts
        run_map(1'b0, 1'b1, 3, 6, 1'b0, 1'b0, 0, "R5");
        step(1'b0, 0, 0, 1'b1, 2, 511);
        run_map(1'b1, 1'b1, 2, 7, 1'b1, 1'b0, 1, "R5");
        run_map(1'b1, 1'b0, 2, 8, 1'b0, 1'b0, 1, "R4");
        step(1'b0, 0, 0, 1'b1, 0, -512);
        run_map(1'b0, 1'b1, 0, 9, 1'b0, 1'b0, 1, "R5");
        // R6: threshold of the same channel rewritten on every beat
        run_map(1'b1, 1'b0, 3, 10, 1'b0, 1'b1, 0, "R6");
        run_map(1'b0, 1'b0, 1, 11, 1'b1, 1'b1, 0, "R6");
        // R8: all expected pooled results consumed
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d results missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule